// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns single-bit requests from a byte engine (start condition, data bit, stop condition) into timed open-drain enables for the SCL and SDA lines of an I2C master. Every interval is a programmable count of register-clock cycles. The intervals are the clock low period, the clock high period, the time SDA must settle before SCL is released, and the stop setup time. A separate detector uses a one-cycle microsecond tick to decide when the bus has been quiet long enough to be called idle.

The generator releases SCL only at the end of the low period. It then waits until the line really reads high, so another device that stretches the clock simply lengthens the low time. The high period and the stop setup time are counted from the first cycle in which SCL is sampled high.

The four timing counts are copied into private holding registers only when a start is issued on an idle bus. Software may therefore rewrite the live values in the middle of a transfer without changing any bit of that transfer.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, `scl_oe`, `sda_oe`, `op_done`, `bus_idle` and `req_ready` are all 0.
- R2: `bus_idle` rises on the clock edge at which the N-th `us_tick` is seen while both lines have stayed high, where N is `cfg_idle` and a value of 0 counts as 1. Any sample with either line low clears the flag and the tick count at that edge.
- R3: `req_ready` is 1 only while no operation is in progress and either the master holds SCL low or `bus_idle` is 1. A request is taken on an edge where `req_valid` and `req_ready` are both 1. The `req_op` code 0 is a start, 1 is a data bit, and 2 or 3 is a stop.
- R4: A start taken while SCL is released drives `sda_oe` to 1 on the accepting edge. It then drives `scl_oe` to 1 exactly max(high,1) cycles later, and `op_done` pulses on that same edge.
- R5: A data bit, stop or repeated start releases SCL (`scl_oe` to 0) exactly L = max(low,1) cycles after the accepting edge. SDA moves to its target exactly min(setup, L) cycles before that release, and this happens on the accepting edge when setup is at least L. The target is `sda_oe` = NOT `req_bit` for a bit, 1 for a stop, and 0 for a repeated start.
- R6: After releasing SCL the generator waits as long as `scl_in` reads low. For a data bit it drives SCL low again exactly max(high,1)+1 cycles after the line is first high.
- R7: On the edge that ends a data bit, `rx_bit` takes the value of `sda_in` and `op_done` pulses high for one cycle. `sda_oe` does not change while SCL is high during a data bit.
- R8: A repeated start, after SCL is released and seen high, drives `sda_oe` to 1 exactly max(high,1)+1 cycles after the line rose. It then drives `scl_oe` to 1 exactly max(high,1) cycles after that, with `op_done`.
- R9: A stop releases SDA (`sda_oe` to 0) exactly max(stop,1)+1 cycles after the SCL line rises, with `op_done`, and leaves both enables at 0.
- R10: The low, high, setup and stop counts in use are captured only when a start is accepted while the bus is idle. Changes to `cfg_low`, `cfg_high`, `cfg_setup` and `cfg_stop` at any other time do not affect timing until the next such start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_low | input | CW | SCL low period, register-clock cycles |
| cfg_high | input | CW | SCL high period / start hold, register-clock cycles |
| cfg_setup | input | CW | SDA settle time before SCL release |
| cfg_stop | input | CW | Stop setup time |
| cfg_idle | input | IW | Idle-detect length in microsecond ticks |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 start, 1 bit, 2/3 stop |
| req_bit | input | 1 | Data value for a bit request |
| req_ready | output | 1 | Request can be taken |
| op_done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | SDA sampled at end of last data bit |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| bus_idle | output | 1 | Bus quiet for the idle-detect time |

## Verification
The assertions take for granted that `scl_in` and `sda_in` are already synchronized to `clk`. They also assume that `us_tick` is a single-cycle pulse, that data-bit and stop requests arrive only while the master holds SCL low after a start, and that request fields stay steady while `req_valid` is high. The bench respects all of this by building the sampled lines from the block's own open-drain enables, ANDed with a stretching device and a slave pull-down. It issues operations only in a legal start–bits–stop order and changes the live timing values only between operations.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BIT   = 2'd1,
    OP_STOP  = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    PH_READY,
    PH_LOW,
    PH_RELEASE,
    PH_HIGH,
    PH_HOLD,
    PH_STOPSU
  } phase_e;

  function automatic op_e decode_op(input logic [1:0] code);
    if (code[1])      return OP_STOP;
    else if (code[0]) return OP_BIT;
    else              return OP_START;
  endfunction

endpackage

// File: rtl/i2c_tg_shadow.sv
module i2c_tg_shadow #(
  parameter int NF = 4,
  parameter int W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NF-1:0][W-1:0] live,
  output logic [NF-1:0][W-1:0] held
);

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)       r <= '0;
      else if (load) r <= live[g];
    end
    assign held[g] = r;
  end

endmodule

// File: rtl/i2c_tg_idle.sv
module i2c_tg_idle #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          us_tick,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [IW-1:0] idle_cnt,
  output logic          bus_idle
);

  localparam logic [IW-1:0] ONE = {{(IW-1){1'b0}}, 1'b1};

  logic [IW-1:0] ticks;
  logic [IW-1:0] target;

  assign target = (idle_cnt == '0) ? ONE : idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !scl_in || !sda_in) begin
      ticks    <= '0;
      bus_idle <= 1'b0;
    end else if (us_tick && !bus_idle) begin
      if (ticks >= target - ONE) bus_idle <= 1'b1;
      else                       ticks    <= ticks + ONE;
    end
  end

  // R2: a low line on either wire removes the idle flag at the next edge
  a_r2_low_clears: assert property (@(posedge clk) disable iff (rst)
    (!scl_in || !sda_in) |=> !bus_idle);

  // R2: the flag only ever rises on a tick
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_idle) |-> $past(us_tick));

endmodule

// File: rtl/i2c_tg_elapsed.sv
module i2c_tg_elapsed #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clr)       count <= '0;
    else if (count != '1) count <= count + 1'b1;
  end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_tg_pkg::*;
#(
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_high,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_stop,
  input  logic [IW-1:0] cfg_idle,
  input  logic          us_tick,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_bit,
  output logic          req_ready,
  output logic          op_done,
  output logic          rx_bit,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          bus_idle
);

  localparam int NF = 4;
  localparam int F_LOW = 0, F_HIGH = 1, F_SET = 2, F_STOP = 3;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  // timing holding registers
  logic [NF-1:0][CW-1:0] live_vec, shd_vec;
  logic                  shd_load;

  assign live_vec[F_LOW]  = cfg_low;
  assign live_vec[F_HIGH] = cfg_high;
  assign live_vec[F_SET]  = cfg_setup;
  assign live_vec[F_STOP] = cfg_stop;

  i2c_tg_shadow #(.NF(NF), .W(CW)) u_shadow (
    .clk(clk), .rst(rst), .load(shd_load), .live(live_vec), .held(shd_vec)
  );

  i2c_tg_idle #(.IW(IW)) u_idle (
    .clk(clk), .rst(rst), .us_tick(us_tick), .scl_in(scl_in), .sda_in(sda_in),
    .idle_cnt(cfg_idle), .bus_idle(bus_idle)
  );

  // effective lengths
  logic [CW-1:0] len_low, len_high, len_stop, set_eff, sda_point;
  logic          early_sda;

  assign len_low   = (shd_vec[F_LOW]  == '0) ? ONE : shd_vec[F_LOW];
  assign len_high  = (shd_vec[F_HIGH] == '0) ? ONE : shd_vec[F_HIGH];
  assign len_stop  = (shd_vec[F_STOP] == '0) ? ONE : shd_vec[F_STOP];
  assign early_sda = (shd_vec[F_SET] >= len_low);
  assign set_eff   = early_sda ? len_low : shd_vec[F_SET];
  assign sda_point = len_low - set_eff - ONE;

  // phase state and elapsed counter
  phase_e        phase, phase_nxt;
  op_e           cur_op, req_kind;
  logic          tgt_sda, req_tgt;
  logic [CW-1:0] el;

  i2c_tg_elapsed #(.W(CW)) u_elapsed (
    .clk(clk), .rst(rst), .clr(phase_nxt != phase), .count(el)
  );

  assign req_kind  = decode_op(req_op);
  assign req_tgt   = (req_kind == OP_STOP) ? 1'b1 :
                     (req_kind == OP_BIT)  ? ~req_bit : 1'b0;
  assign req_ready = (phase == PH_READY) && (scl_oe || bus_idle);

  logic accept, start_idle, low_end, sda_hit, rel_seen, high_end, hold_end, su_end;

  assign accept     = req_valid && req_ready;
  assign start_idle = accept && (req_kind == OP_START) && !scl_oe;
  assign shd_load   = start_idle;
  assign low_end    = (phase == PH_LOW) && (el == len_low - ONE);
  assign sda_hit    = (phase == PH_LOW) && !early_sda && (el == sda_point);
  assign rel_seen   = (phase == PH_RELEASE) && scl_in;
  assign high_end   = (phase == PH_HIGH) && (el == len_high - ONE);
  assign hold_end   = (phase == PH_HOLD) && (el == len_high - ONE);
  assign su_end     = (phase == PH_STOPSU) && (el == len_stop - ONE);

  always_comb begin
    phase_nxt = phase;
    case (phase)
      PH_READY:   if (accept)   phase_nxt = start_idle ? PH_HOLD : PH_LOW;
      PH_LOW:     if (low_end)  phase_nxt = PH_RELEASE;
      PH_RELEASE: if (rel_seen) phase_nxt = (cur_op == OP_STOP) ? PH_STOPSU : PH_HIGH;
      PH_HIGH:    if (high_end) phase_nxt = (cur_op == OP_START) ? PH_HOLD : PH_READY;
      PH_HOLD:    if (hold_end) phase_nxt = PH_READY;
      PH_STOPSU:  if (su_end)   phase_nxt = PH_READY;
      default:                  phase_nxt = PH_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_READY;
      cur_op  <= OP_START;
      tgt_sda <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      rx_bit  <= 1'b0;
      op_done <= 1'b0;
    end else begin
      phase   <= phase_nxt;
      op_done <= 1'b0;
      if (accept) begin
        cur_op  <= req_kind;
        tgt_sda <= req_tgt;
        if (start_idle)     sda_oe <= 1'b1;
        else if (early_sda) sda_oe <= req_tgt;
      end
      if (sda_hit) sda_oe <= tgt_sda;
      if (low_end) scl_oe <= 1'b0;
      if (high_end) begin
        if (cur_op == OP_START) begin
          sda_oe <= 1'b1;
        end else begin
          scl_oe  <= 1'b1;
          rx_bit  <= sda_in;
          op_done <= 1'b1;
        end
      end
      if (hold_end) begin
        scl_oe  <= 1'b1;
        op_done <= 1'b1;
      end
      if (su_end) begin
        sda_oe  <= 1'b0;
        op_done <= 1'b1;
      end
    end
  end

  // R4: a start from a released clock only begins on an idle bus
  a_r4_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && !scl_oe && $past(phase) == PH_READY) |-> $past(bus_idle));

  // R6: while the line is held low by someone else, the generator keeps waiting
  a_r6_wait_high: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RELEASE && !scl_in) |=> (phase == PH_RELEASE && !scl_oe));

  // R7: data does not move while the clock is high in a data bit
  a_r7_sda_steady: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH && cur_op == OP_BIT) |=> $stable(sda_oe));

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

  // R9: during stop setup the clock is released
  a_r9_stop_scl_released: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STOPSU) |-> !scl_oe);

  // R10: held timing only changes when the bus was idle
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_idle |=> $stable(shd_vec));

endmodule

// File: tb/tb_i2c_bit_timer.sv
module tb_i2c_bit_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_low = 16'd10, cfg_high = 16'd5, cfg_setup = 16'd3, cfg_stop = 16'd4;
  logic [15:0] cfg_idle = 16'd3;
  logic        us_tick = 1'b0;
  logic        req_valid = 1'b0, req_bit = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic        stretch = 1'b0, slv_low = 1'b0;
  logic        req_ready, op_done, rx_bit, scl_oe, sda_oe, bus_idle;
  logic        scl_in, sda_in;

  int n_chk = 0, n_fail = 0, cyc = 0, tcnt = 0, div = 0;

  assign scl_in = !scl_oe && !stretch;
  assign sda_in = !sda_oe && !slv_low;

  i2c_bit_timer dut (
    .clk(clk), .rst(rst), .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_setup(cfg_setup),
    .cfg_stop(cfg_stop), .cfg_idle(cfg_idle), .us_tick(us_tick), .scl_in(scl_in),
    .sda_in(sda_in), .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit),
    .req_ready(req_ready), .op_done(op_done), .rx_bit(rx_bit), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .bus_idle(bus_idle)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst || !scl_in || !sda_in) tcnt <= 0;
    else if (us_tick)              tcnt <= tcnt + 1;
  end

  initial forever begin
    @(negedge clk);
    div     = (div == 3) ? 0 : div + 1;
    us_tick = (div == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic issue(input logic [1:0] op, input logic b, output int t_acc);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bit = b;
    @(negedge clk);
    req_valid = 1'b0;
    t_acc = cyc;
  endtask

  task automatic wait_scl(input logic v, output int t);
    while (scl_oe !== v) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_sda(input logic v, output int t);
    while (sda_oe !== v) @(negedge clk);
    t = cyc;
  endtask

  task automatic t_wait_idle(input int n_exp);
    while (!bus_idle) @(negedge clk);
    chk("R2 ticks counted when idle rises", tcnt, n_exp);
    chk("R3 ready once idle", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 scl_oe in reset", int'(scl_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl_oe after reset", int'(scl_oe), 0);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 done/idle/ready after reset", int'({op_done, bus_idle, req_ready}), 0);
  endtask

  task automatic t_idle_glitch();
    t_wait_idle(3);
    slv_low = 1'b1;
    @(negedge clk);
    chk("R2 sda low clears idle", int'(bus_idle), 0);
    chk("R3 not ready while busy", int'(req_ready), 0);
    slv_low = 1'b0;
    t_wait_idle(3);
  endtask

  task automatic t_start_idle(input int h);
    int ta, t;
    issue(2'd0, 1'b0, ta);
    chk("R4 sda driven at accept", int'(sda_oe), 1);
    chk("R4 scl still released", int'(scl_oe), 0);
    wait_scl(1'b1, t);
    chk("R4 start hold length", t - ta, h);
    chk("R4 done with start", int'(op_done), 1);
  endtask

  task automatic t_bit(input logic b, input int l, input int s, input int h, input logic rx_exp);
    int ta, ts, tr, th;
    issue(2'd1, b, ta);
    wait_sda(!b, ts);
    wait_scl(1'b0, tr);
    chk("R5 release after low", tr - ta, l);
    chk("R5 sda setup", tr - ts, s);
    wait_scl(1'b1, th);
    chk("R6 high length", th - tr, h + 1);
    chk("R7 done pulse", int'(op_done), 1);
    chk("R7 rx_bit", int'(rx_bit), int'(rx_exp));
  endtask

  task automatic t_stretch(input int l, input int h);
    int ta, ts, tr, tu, th, bad;
    bad = 0;
    stretch = 1'b1;
    issue(2'd1, 1'b0, ta);
    wait_sda(1'b1, ts);
    wait_scl(1'b0, tr);
    chk("R5 release under stretch", tr - ta, l);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (scl_oe || op_done) bad++;
    end
    chk("R6 waits while stretched", bad, 0);
    stretch = 1'b0;
    tu = cyc;
    wait_scl(1'b1, th);
    chk("R6 high counted from line rise", th - tu, h + 1);
    chk("R7 rx_bit after stretch", int'(rx_bit), 0);
  endtask

  task automatic t_rep_start(input int l, input int h);
    int ta, tr, ts, th;
    issue(2'd0, 1'b0, ta);
    wait_scl(1'b0, tr);
    chk("R5 repeated start release", tr - ta, l);
    wait_sda(1'b1, ts);
    chk("R8 sda low after high", ts - tr, h + 1);
    wait_scl(1'b1, th);
    chk("R8 hold before scl low", th - ts, h);
    chk("R8 done", int'(op_done), 1);
  endtask

  task automatic t_stop(input int l, input int p);
    int ta, tr, ts;
    issue(2'd2, 1'b0, ta);
    wait_scl(1'b0, tr);
    chk("R5 stop release", tr - ta, l);
    wait_sda(1'b0, ts);
    chk("R9 stop setup", ts - tr, p + 1);
    chk("R9 done", int'(op_done), 1);
    chk("R9 both released", int'({scl_oe, sda_oe}), 0);
    chk("R3 no request while bus busy", int'(req_ready), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_idle_glitch();
    t_start_idle(5);
    t_bit(1'b1, 10, 3, 5, 1'b1);
    t_bit(1'b0, 10, 3, 5, 1'b0);
    slv_low = 1'b1;
    t_bit(1'b1, 10, 3, 5, 1'b0);
    slv_low = 1'b0;
    t_stretch(10, 5);
    // R10: rewrite live values mid-transfer; old timing must persist
    cfg_low = 16'd4; cfg_high = 16'd2; cfg_setup = 16'd20; cfg_stop = 16'd1;
    t_bit(1'b1, 10, 3, 5, 1'b1);
    t_rep_start(10, 5);
    t_stop(10, 4);
    t_wait_idle(3);
    // R10: new values take effect at the next start on an idle bus
    t_start_idle(2);
    t_bit(1'b1, 4, 4, 2, 1'b1);
    t_stop(4, 1);
    cfg_low = 16'd0; cfg_high = 16'd0; cfg_setup = 16'd0; cfg_stop = 16'd0; cfg_idle = 16'd0;
    t_wait_idle(1);
    t_start_idle(1);
    t_stop(1, 1);
    summary();
    $finish;
  end

endmodule